// File: doc/BRIEF.md
# SD Command Line Sequencer

This block runs a single command exchange on the one-bit command line of an SD or MMC card. Software sets up a command index, a 32-bit argument, a set of option flags and a response timeout. It then pulses a start request. The block latches that setup and serialises a 48-bit command frame, generating the CRC7 checksum itself. After the frame it does one of two things. If no answer is expected, it clocks out a short idle tail. Otherwise it waits for the card's start bit, receives a 48-bit or 136-bit answer, checks it, and posts the result words and status flags. The run indication then drops.

All line activity advances only on cycles where the bus-clock enable `bus_en` is high. Each such cycle is one card bus clock, called a tick below. The start request is accepted on any clock cycle while the block is idle.

The sequencer has six states, which it passes through in this order:
- `ST_IDLE`: waiting for a start request.
- `ST_SEND`: shifting out the 48 frame bits.
- `ST_TAIL`: eight idle ticks, used when no answer is expected.
- `ST_GAP`: two ticks after the end bit during which the line is not examined.
- `ST_WAIT`: looking for the start bit while counting the timeout.
- `ST_RECV`: taking in the rest of the answer.

Its transitions are:
- `ST_IDLE` to `ST_SEND` on accept.
- `ST_SEND` to `ST_TAIL` or to `ST_GAP` on the end bit, depending on whether an answer is expected.
- `ST_TAIL` to `ST_IDLE` after eight ticks.
- `ST_GAP` to `ST_WAIT` after two ticks.
- `ST_WAIT` to `ST_RECV` when a start bit is seen.
- `ST_WAIT` to `ST_IDLE` when the timeout expires.
- `ST_RECV` to `ST_IDLE` on the last answer bit.

Top module: `sd_cmd_seq`

## Requirements
- R1: The command frame is sent MSB first, one bit per tick, starting on the first tick after acceptance. Its bits are:
  - a 0, then a 1;
  - `cmd_index[5:0]`;
  - `cmd_arg[31:0]`;
  - CRC7 (polynomial x^7+x^3+1, initial value 0) over the preceding 40 bits;
  - a final 1.
  
  `cmd_index[7:6]` must be zero when a start is requested.
- R2: `run_set` is accepted only in `ST_IDLE`. From the cycle after acceptance, `run` and `busy` are both 1 until the transaction completes, and both are 0 otherwise.
- R3: `cmd_out` is 1 whenever the block is not in `ST_SEND`, including after reset.
- R4: With `want_resp` = 0, eight ticks with `cmd_out` = 1 follow the end bit. `run` clears on the eighth of them.
- R5: With `want_resp` = 1, the line is ignored on the two ticks after the end bit. Start-bit detection begins on the third tick.
- R6: For a short answer (received bits 47..0), `resp_word0` receives bits 39..8 and `resp_word1`..`resp_word3` are cleared.
- R7: For a long answer (received bits 135..0), `resp_wordK` receives bits 32K+31..32K for K = 0..3, so word 0 holds the least significant part.
- R8: The answer CRC7 is compared with received bits 7..1. It is computed over bits 47..8 for a short answer and over bits 127..8 for a long one. A mismatch sets `st_crc_err`.
- R9: With `skip_crc` = 1, `st_crc_err` stays 0 whatever the received checksum, and the answer words are still stored.
- R10: For a short answer, `st_resp_err` is set when received bits 45..40 differ from the sent index. For a long answer this comparison is not made.
- R11: With timeout value T, if T consecutive sampled ticks in `ST_WAIT` are all 1, then `st_timeout` is set and `run` clears on the T-th such tick. A value of 0 gives 65536.
- R12: All three status flags are cleared on acceptance and change only when the transaction completes.
- R13: A `run_set` pulse while busy is ignored. The latched index, argument and flags stay in effect for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | One-cycle enable marking each card bus clock |
| run_set | input | 1 | Start request |
| cmd_index | input | 8 | Command index (upper two bits zero) |
| cmd_arg | input | 32 | Command argument |
| want_resp | input | 1 | Expect an answer from the card |
| long_resp | input | 1 | Expect a 136-bit answer instead of 48 bits |
| skip_crc | input | 1 | Do not check the answer CRC |
| resp_tmo | input | 16 | Start-bit timeout in ticks (0 = 65536) |
| cmd_in | input | 1 | Sampled command line from the card |
| cmd_out | output | 1 | Driven command line, high when idle |
| run | output | 1 | Transaction in progress, self-clearing |
| busy | output | 1 | Command busy status |
| st_crc_err | output | 1 | Answer CRC mismatch |
| st_resp_err | output | 1 | Echoed index mismatch |
| st_timeout | output | 1 | No start bit within the timeout |
| resp_word0 | output | 32 | Answer word 0 (least significant) |
| resp_word1 | output | 32 | Answer word 1 |
| resp_word2 | output | 32 | Answer word 2 |
| resp_word3 | output | 32 | Answer word 3 (most significant) |

## Verification
The embedded assertions check several properties on every cycle:
- the line stays high outside `ST_SEND`;
- `run` agrees with `busy`;
- the latched setup is frozen while busy;
- the flags move only at the falling edge of `run`;
- a skipped CRC never raises its flag;
- a timeout never coincides with another error.

Only the directed scenarios can show the rest, because that needs an independent card model on the other end:
- the exact serial frame and its CRC;
- the answer word mapping;
- the gap in which the line is ignored;
- the tick on which a timeout or tail ends;
- the detection of bad checksums and mismatched index echoes.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int ARG_W       = 32;
    localparam int IDX_FIELD_W = 6;
    localparam int CRC_W       = 7;
    localparam int CRC_SPAN    = 2 + IDX_FIELD_W + ARG_W;
    localparam int CMD_BITS    = CRC_SPAN + CRC_W + 1;
    localparam int WORD_W      = 32;
    localparam int NUM_WORDS   = 4;
    localparam int KEEP_W      = WORD_W * NUM_WORDS;
    localparam int SHORT_BITS  = 48;
    localparam int LONG_BITS   = KEEP_W + 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_TAIL = 3'd2,
        ST_GAP  = 3'd3,
        ST_WAIT = 3'd4,
        ST_RECV = 3'd5
    } seq_state_t;

    // One serial step of the x^7 + x^3 + 1 checksum.
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    // Checksum over the leading part of a command frame, MSB first.
    function automatic logic [CRC_W-1:0] crc7_span(input logic [CRC_SPAN-1:0] d);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            c = crc7_step(c, d[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sd_crc7_serial.sv
module sd_crc7_serial
    import sd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end

endmodule

// File: rtl/sd_cmd_txshift.sv
module sd_cmd_txshift #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] frame_in,
    input  logic         shift,
    output logic         msb
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= frame_in;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b1};
        end
    end

    assign msb = sr_q[W-1];

endmodule

// File: rtl/sd_resp_shift.sv
module sd_resp_shift #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] peek
);

    // Holds the W-1 most recent bits; peek appends the bit on the line now.
    logic [W-2:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
        end else if (en) begin
            hist_q <= peek[W-2:0];
        end
    end

    assign peek = {hist_q, din};

endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
    import sd_cmd_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int TAIL_CLKS = 8,
    parameter int GAP_CLKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              run_set,
    input  logic [7:0]        cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              want_resp,
    input  logic              long_resp,
    input  logic              skip_crc,
    input  logic [TMO_W-1:0]  resp_tmo,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              run,
    output logic              busy,
    output logic              st_crc_err,
    output logic              st_resp_err,
    output logic              st_timeout,
    output logic [WORD_W-1:0] resp_word0,
    output logic [WORD_W-1:0] resp_word1,
    output logic [WORD_W-1:0] resp_word2,
    output logic [WORD_W-1:0] resp_word3
);

    localparam int CNT_W = $clog2(LONG_BITS);
    localparam logic [CNT_W-1:0] SEND_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_CLKS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CLKS - 1);
    localparam logic [CNT_W-1:0] RX_LAST_S  = CNT_W'(SHORT_BITS - 2);
    localparam logic [CNT_W-1:0] RX_LAST_L  = CNT_W'(LONG_BITS - 2);
    // Receive counter value b takes in answer bit b+1 (the start bit is bit 0).
    localparam logic [CNT_W-1:0] CRC_HI_S   = CNT_W'(SHORT_BITS - 8 - 2);
    localparam logic [CNT_W-1:0] CRC_LO_L   = CNT_W'(7);
    localparam logic [CNT_W-1:0] CRC_HI_L   = CNT_W'(LONG_BITS - 8 - 2);
    localparam int STAT_LO   = 8;
    localparam int ECHO_LO   = STAT_LO + WORD_W;

    seq_state_t state_q, state_d;

    logic [CNT_W-1:0]       bit_cnt_q;
    logic [TMO_W-1:0]       wait_cnt_q;
    logic [IDX_FIELD_W-1:0] idx_q;
    logic                   want_q, long_q, skip_q;
    logic [TMO_W-1:0]       tmo_q;
    logic [WORD_W-1:0]      words_q [NUM_WORDS];

    logic                   accept;
    logic                   tx_msb;
    logic [CMD_BITS-1:0]    tx_frame;
    logic [CRC_W-1:0]       rx_crc;
    logic [KEEP_W-1:0]      rx_full;
    logic                   rx_shift_en, rx_crc_en;
    logic                   start_seen, tmo_hit, rx_done;
    logic [CNT_W-1:0]       rx_last;
    logic                   crc_bad, echo_bad;
    logic [WORD_W-1:0]      long_word [NUM_WORDS];

    assign accept     = run_set && (state_q == ST_IDLE);
    assign busy       = (state_q != ST_IDLE);
    assign start_seen = bus_en && (state_q == ST_WAIT) && !cmd_in;
    assign tmo_hit    = bus_en && (state_q == ST_WAIT) && cmd_in
                        && ((wait_cnt_q + TMO_W'(1)) == tmo_q);
    assign rx_last    = long_q ? RX_LAST_L : RX_LAST_S;
    assign rx_done    = bus_en && (state_q == ST_RECV) && (bit_cnt_q == rx_last);

    // Outgoing frame built from the live inputs at the accept cycle.
    always_comb begin
        logic [CRC_SPAN-1:0] head;
        head     = {1'b0, 1'b1, cmd_index[IDX_FIELD_W-1:0], cmd_arg};
        tx_frame = {head, crc7_span(head), 1'b1};
    end

    sd_cmd_txshift #(.W(CMD_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .frame_in (tx_frame),
        .shift    (bus_en && (state_q == ST_SEND)),
        .msb      (tx_msb)
    );

    // Checksum window: answer bits 1..39 (short) or 8..127 (long).
    always_comb begin
        rx_crc_en = 1'b0;
        if (bus_en && (state_q == ST_RECV)) begin
            if (long_q) begin
                rx_crc_en = (bit_cnt_q >= CRC_LO_L) && (bit_cnt_q <= CRC_HI_L);
            end else begin
                rx_crc_en = (bit_cnt_q <= CRC_HI_S);
            end
        end
    end

    assign rx_shift_en = start_seen || (bus_en && (state_q == ST_RECV));

    sd_crc7_serial u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (rx_crc_en),
        .din   (cmd_in),
        .crc   (rx_crc)
    );

    sd_resp_shift #(.W(KEEP_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (rx_shift_en),
        .din   (cmd_in),
        .peek  (rx_full)
    );

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign long_word[g] = rx_full[g*WORD_W +: WORD_W];
    end

    assign crc_bad  = !skip_q && (rx_crc != rx_full[CRC_W:1]);
    assign echo_bad = !long_q && (rx_full[ECHO_LO +: IDX_FIELD_W] != idx_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_SEND;
            ST_SEND: if (bus_en && bit_cnt_q == SEND_LAST)
                         state_d = want_q ? ST_GAP : ST_TAIL;
            ST_TAIL: if (bus_en && bit_cnt_q == TAIL_LAST) state_d = ST_IDLE;
            ST_GAP:  if (bus_en && bit_cnt_q == GAP_LAST)  state_d = ST_WAIT;
            ST_WAIT: begin
                if (start_seen)   state_d = ST_RECV;
                else if (tmo_hit) state_d = ST_IDLE;
            end
            ST_RECV: if (rx_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counters, latched setup and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            wait_cnt_q  <= '0;
            idx_q       <= '0;
            want_q      <= 1'b0;
            long_q      <= 1'b0;
            skip_q      <= 1'b0;
            tmo_q       <= '0;
            cmd_out     <= 1'b1;
            run         <= 1'b0;
            st_crc_err  <= 1'b0;
            st_resp_err <= 1'b0;
            st_timeout  <= 1'b0;
            for (int k = 0; k < NUM_WORDS; k++) words_q[k] <= '0;
        end else begin
            if (accept) begin
                idx_q       <= cmd_index[IDX_FIELD_W-1:0];
                want_q      <= want_resp;
                long_q      <= long_resp;
                skip_q      <= skip_crc;
                tmo_q       <= resp_tmo;
                bit_cnt_q   <= '0;
                run         <= 1'b1;
                st_crc_err  <= 1'b0;
                st_resp_err <= 1'b0;
                st_timeout  <= 1'b0;
            end else if (bus_en) begin
                unique case (state_q)
                    ST_IDLE: cmd_out <= 1'b1;
                    ST_SEND: begin
                        cmd_out   <= tx_msb;
                        bit_cnt_q <= (bit_cnt_q == SEND_LAST) ? '0 : bit_cnt_q + 1'b1;
                    end
                    ST_TAIL: begin
                        cmd_out <= 1'b1;
                        if (bit_cnt_q == TAIL_LAST) begin
                            bit_cnt_q <= '0;
                            run       <= 1'b0;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    ST_GAP: begin
                        cmd_out    <= 1'b1;
                        wait_cnt_q <= '0;
                        bit_cnt_q  <= (bit_cnt_q == GAP_LAST) ? '0 : bit_cnt_q + 1'b1;
                    end
                    ST_WAIT: begin
                        cmd_out <= 1'b1;
                        if (start_seen) begin
                            bit_cnt_q <= '0;
                        end else if (tmo_hit) begin
                            st_timeout <= 1'b1;
                            run        <= 1'b0;
                        end else begin
                            wait_cnt_q <= wait_cnt_q + 1'b1;
                        end
                    end
                    ST_RECV: begin
                        cmd_out <= 1'b1;
                        if (rx_done) begin
                            bit_cnt_q   <= '0;
                            run         <= 1'b0;
                            st_crc_err  <= crc_bad;
                            st_resp_err <= echo_bad;
                            for (int k = 0; k < NUM_WORDS; k++) begin
                                if (long_q)      words_q[k] <= long_word[k];
                                else if (k == 0) words_q[k] <= rx_full[STAT_LO +: WORD_W];
                                else             words_q[k] <= '0;
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    default: cmd_out <= 1'b1;
                endcase
            end
        end
    end

    assign resp_word0 = words_q[0];
    assign resp_word1 = words_q[1];
    assign resp_word2 = words_q[2];
    assign resp_word3 = words_q[3];

    // R1
    idx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (cmd_index[7:IDX_FIELD_W] == '0));

    // R2
    run_busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run == busy);

    // R3
    line_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SEND) |-> cmd_out);

    // R4
    tail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> (bit_cnt_q < CNT_W'(TAIL_CLKS)));

    // R9
    skip_no_crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_q |-> !st_crc_err);

    // R11
    timeout_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_timeout |-> (!st_crc_err && !st_resp_err));

    // R12
    flags_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_crc_err) || $rose(st_resp_err) || $rose(st_timeout)) |-> $fell(run));

    // R13
    setup_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(idx_q) && $stable(want_q) && $stable(long_q) && $stable(skip_q)));

endmodule

// File: tb/sd_cmd_seq_bench.sv
module sd_cmd_seq_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        run_set = 1'b0;
    logic [7:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        want_resp = 1'b0;
    logic        long_resp = 1'b0;
    logic        skip_crc = 1'b0;
    logic [15:0] resp_tmo = '0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, run, busy, st_crc_err, st_resp_err, st_timeout;
    logic [31:0] resp_word0, resp_word1, resp_word2, resp_word3;

    int checks = 0;
    int errors = 0;
    int div_cnt = 0;
    bit finished = 0;

    sd_cmd_seq u_sd_cmd_seq (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .run_set(run_set),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .want_resp(want_resp),
        .long_resp(long_resp), .skip_crc(skip_crc), .resp_tmo(resp_tmo),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .run(run), .busy(busy),
        .st_crc_err(st_crc_err), .st_resp_err(st_resp_err), .st_timeout(st_timeout),
        .resp_word0(resp_word0), .resp_word1(resp_word1),
        .resp_word2(resp_word2), .resp_word3(resp_word3)
    );

    always #(CLK_P/2) clk = ~clk;

    // Bus-clock enable: one cycle in three, changed away from the active edge.
    always @(negedge clk) begin
        div_cnt <= (div_cnt == 2) ? 0 : div_cnt + 1;
        bus_en  <= (div_cnt == 2);
    end

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        do @(posedge clk); while (!bus_en);
        @(negedge clk);
    endtask

    // Start a command, capture the 48 frame bits and compare them.
    task automatic start_and_send(input logic [5:0] idx, input logic [31:0] arg,
                                  input bit wr, input bit lr, input bit sk,
                                  input logic [15:0] tmo, input bit poke_busy);
        logic [47:0] got, exp;
        logic [135:0] hv;
        @(negedge clk);
        cmd_index = {2'b00, idx}; cmd_arg = arg; want_resp = wr;
        long_resp = lr; skip_crc = sk; resp_tmo = tmo; run_set = 1'b1;
        @(posedge clk); @(negedge clk);
        run_set = 1'b0;
        check("R2 run after accept", {126'd0, run, busy}, 128'd3);
        check("R12 flags cleared on accept", {125'd0, st_crc_err, st_resp_err, st_timeout}, 128'd0);
        hv = '0;
        hv[39:0] = {2'b01, idx, arg};
        exp = {2'b01, idx, arg, ref_crc(hv, 39, 0), 1'b1};
        for (int k = 0; k < 48; k++) begin
            if (poke_busy && k == 10) begin
                run_set = 1'b1; cmd_index = 8'h3F; cmd_arg = ~arg;
                want_resp = ~wr; long_resp = ~lr; skip_crc = ~sk;
            end else if (poke_busy && k == 12) begin
                run_set = 1'b0;
            end
            tick();
            got[47-k] = cmd_out;
        end
        check(poke_busy ? "R13 frame unchanged by busy start" : "R1 frame", {80'd0, got}, {80'd0, exp});
    endtask

    // Card side: optional low pulse during the gap, delay, then the answer bits.
    task automatic card_answer(input logic [135:0] rf, input int nbits,
                               input int delay, input bit gap_low);
        for (int g = 0; g < 2; g++) begin
            cmd_in = gap_low ? 1'b0 : 1'b1;
            tick();
        end
        cmd_in = 1'b1;
        for (int d = 0; d < delay; d++) tick();
        for (int i = nbits - 1; i >= 0; i--) begin
            cmd_in = rf[i];
            if (i == 0) check("R2 run before last bit", {127'd0, run}, 128'd1);
            tick();
        end
        cmd_in = 1'b1;
        check("R2 run cleared at end", {126'd0, run, busy}, 128'd0);
    endtask

    function automatic logic [135:0] short_frame(input logic [5:0] idx,
                                                 input logic [31:0] st, input bit bad_crc);
        logic [135:0] f = '0;
        f[47:8] = {2'b00, idx, st};
        f[7:1] = ref_crc(f, 47, 8) ^ (bad_crc ? 7'h01 : 7'h00);
        f[0] = 1'b1;
        return f;
    endfunction

    task automatic t_reset();
        check("R3 reset line high", {127'd0, cmd_out}, 128'd1);
        check("R2 reset idle", {126'd0, run, busy}, 128'd0);
        check("R12 reset flags", {125'd0, st_crc_err, st_resp_err, st_timeout}, 128'd0);
        check("R6 reset words", {resp_word3, resp_word2, resp_word1, resp_word0}, 128'd0);
    endtask

    task automatic t_no_resp();
        int bad_line = 0;
        start_and_send(6'd0, 32'h0, 1'b0, 1'b0, 1'b0, 16'd10, 1'b0);
        for (int j = 0; j < 8; j++) begin
            tick();
            if (!cmd_out) bad_line++;
            check(j < 7 ? "R4 run during tail" : "R4 run clears on eighth tail tick",
                  {127'd0, run}, {127'd0, (j < 7)});
        end
        check("R3 R4 line high in tail", 128'(bad_line), 128'd0);
    endtask

    task automatic t_fixed_frame();
        // Known frame for index 0, argument 0.
        logic [47:0] got;
        @(negedge clk);
        cmd_index = 8'd0; cmd_arg = 32'd0; want_resp = 1'b0; run_set = 1'b1;
        @(posedge clk); @(negedge clk);
        run_set = 1'b0;
        for (int k = 0; k < 48; k++) begin tick(); got[47-k] = cmd_out; end
        check("R1 known frame", {80'd0, got}, {80'd0, 48'h400000000095});
        for (int j = 0; j < 8; j++) tick();
    endtask

    task automatic t_short(input bit bad_crc, input bit sk, input bit bad_echo, input string tag);
        logic [5:0] echo = bad_echo ? 6'd18 : 6'd17;
        start_and_send(6'd17, 32'h1234_5678, 1'b1, 1'b0, sk, 16'd20, 1'b0);
        card_answer(short_frame(echo, 32'h0000_0900, bad_crc), 48, 3, 1'b0);
        check({tag, " word0"}, {96'd0, resp_word0}, {96'd0, 32'h0000_0900});
        check({tag, " words1-3 zero"}, {32'd0, resp_word3, resp_word2, resp_word1}, 128'd0);
        check({tag, " flags"}, {125'd0, st_crc_err, st_resp_err, st_timeout},
              {125'd0, bad_crc && !sk, bad_echo, 1'b0});
    endtask

    task automatic t_long(input bit bad_crc);
        logic [135:0] f = '0;
        logic [119:0] body = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h5A5A5A};
        f[135:128] = 8'h3F;
        f[127:8] = body;
        f[7:1] = ref_crc(f, 127, 8) ^ (bad_crc ? 7'h40 : 7'h00);
        f[0] = 1'b1;
        start_and_send(6'd2, 32'h0, 1'b1, 1'b1, 1'b0, 16'd20, 1'b0);
        card_answer(f, 136, 0, 1'b0);
        check("R7 long words", {resp_word3, resp_word2, resp_word1, resp_word0}, f[127:0]);
        check(bad_crc ? "R8 long crc error" : "R10 R8 long no echo check",
              {125'd0, st_crc_err, st_resp_err, st_timeout}, {125'd0, bad_crc, 2'b00});
    endtask

    task automatic t_timeout(input bit gap_low);
        start_and_send(6'd8, 32'h0000_01AA, 1'b1, 1'b0, 1'b0, 16'd4, 1'b0);
        for (int g = 0; g < 2; g++) begin
            cmd_in = gap_low ? 1'b0 : 1'b1;
            tick();
        end
        cmd_in = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            tick();
            check(gap_low ? "R5 gap low ignored, run" : "R11 run during wait",
                  {127'd0, run}, {127'd0, (i < 4)});
        end
        check("R11 timeout flag", {125'd0, st_crc_err, st_resp_err, st_timeout}, 128'd1);
    endtask

    task automatic t_busy_ignore();
        start_and_send(6'd12, 32'hCAFE_0001, 1'b0, 1'b0, 1'b0, 16'd5, 1'b1);
        run_set = 1'b0; cmd_index = 8'd0;
        for (int j = 0; j < 8; j++) tick();
        check("R13 latched no-answer mode kept", {126'd0, run, cmd_out}, 128'd1);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_frame();
        t_no_resp();
        t_short(1'b0, 1'b0, 1'b0, "R6");
        t_short(1'b1, 1'b0, 1'b0, "R8 short bad crc");
        t_short(1'b1, 1'b1, 1'b0, "R9 skip crc");
        t_short(1'b0, 1'b0, 1'b1, "R10 echo mismatch");
        t_short(1'b0, 1'b0, 1'b0, "R12 flags reset by new run");
        t_long(1'b0);
        t_long(1'b1);
        t_timeout(1'b0);
        t_timeout(1'b1);
        t_busy_ignore();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule